// File: doc/BRIEF.md
# Late-Write Pipelined SRAM Core

This block is a synchronous single-port memory whose words are 36 bits wide, split into four 9-bit lanes. It takes a new read or write command on every clock, with no turnaround cycles between reads and writes. Read data leaves the core one accepted edge after the read command was taken. Write data arrives two accepted edges after its write command. The bidirectional data bus is split into a write-data input, a read-data output and an output-valid flag, which an outer pad ring turns into a tri-state driver.

Two pipeline stages hold each pending command's address, kind and lane mask until its write data turns up. A read that names the word a pending write is about to update sees the incoming lanes merged over the stored word. A back-to-back write-then-read to the same address therefore never returns stale data. Clock-enable stalls freeze the whole pipeline. Deselects flow through the pipeline just as accesses do. The sleep input blanks the outputs and blocks new commands until a short recovery window has passed.

Top module: `lwsram_core`

## Requirements
- R1: A command is taken at a rising edge only when `clk_en_n`=0, `sel1_n`=0, `sel2`=1, `sel3_n`=0, `load_n`=0 and the core is not sleeping or recovering. At such an edge `wr_n`=1 means read and `wr_n`=0 means write. With `load_n`=1 or any select inactive, no command starts.
- R2: For a read taken at accepted edge N, `rdata` holds the addressed word from accepted edge N+1 until the next accepted edge. `rdata_en` is high in that window only while `out_en_n` is low, and follows `out_en_n` without waiting for a clock. A read made with `out_en_n` high leaves the output undriven (dummy read).
- R3: For a write taken at accepted edge N, `rdata_en` is low after edge N+1 whatever `out_en_n` is. `wdata` is stored at accepted edge N+2.
- R4: `lane_en_n[i]` low writes bits [9i+8:9i]. Lanes whose enable is high keep their old contents. With all four enables high the write stores nothing.
- R5: While `clk_en_n` is high an edge is ignored: no command is taken, no write is stored, and `rdata`/`rdata_en` keep their previous values.
- R6: If no command is taken at an accepted edge (deselect or `load_n` high), `rdata_en` is low after the following accepted edge.
- R7: A read taken one accepted edge after a write to the same address returns, lane by lane, the incoming `wdata` for the lanes that write enables and the stored contents for the others.
- R8: While `sleep` is high, `rdata_en` is low and no command is taken. No command is taken at the first two rising edges after `sleep` falls.
- R9: After reset the core is deselected with `rdata_en` low and no pending command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en_n | input | 1 | Clock qualifier, active low; high stalls the core |
| sel1_n | input | 1 | Select, active low |
| sel2 | input | 1 | Select, active high |
| sel3_n | input | 1 | Select, active low |
| load_n | input | 1 | Low to load a new address and start a command |
| wr_n | input | 1 | Command kind: 1 read, 0 write |
| lane_en_n | input | 4 | Per-lane write enables, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | 36 | Write data, presented two accepted edges after its command |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Sleep request, active high |
| rdata | output | 36 | Read data (zero when not driven) |
| rdata_en | output | 1 | High when read data should be driven onto the bus |

## Verification
The bench goes after a read that follows a write to the same word by one command. A core without the bypass returns the old word there, and a core that forwards without the lane mask corrupts the untouched lanes. A stall placed between a write and its data must push back the edge at which the data is captured. A core that counts raw clocks instead would store the wrong bus value or drop the write. Write aborts, reads with the output enable high, load-high cycles and sleep recovery are checked for stray writes, stray drive and commands taken too early. Long random mixes of all of these run against a behavioural memory model.

// File: rtl/lwsram_pkg.sv
package lwsram_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int WORD_W = LANES * LANE_W;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [LANES-1:0]  lanes_t;

  // Take each lane from fresh where sel is set, otherwise from base.
  function automatic word_t lane_merge(input word_t base, input word_t fresh,
                                       input lanes_t sel);
    word_t res;
    res = base;
    for (int i = 0; i < LANES; i++) begin
      if (sel[i]) res[i*LANE_W +: LANE_W] = fresh[i*LANE_W +: LANE_W];
    end
    return res;
  endfunction
endpackage

// File: rtl/lwsram_decode.sv
module lwsram_decode (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic sel1_n,
  input  logic sel2,
  input  logic sel3_n,
  input  logic load_n,
  input  logic wr_n,
  input  logic blocked,
  output logic start,
  output logic start_wr
);
  logic selected;
  assign selected = ~sel1_n & sel2 & ~sel3_n;
  assign start    = selected & ~load_n & ~blocked;
  assign start_wr = ~wr_n;

  // R1: an inactive select or load_n high never starts a command
  a_r1_no_start_unselected: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && (sel1_n || !sel2 || sel3_n || load_n)) |-> !start);
endmodule

// File: rtl/lwsram_wake.sv
module lwsram_wake #(
  parameter int WAKE_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep,
  output logic blocked
);
  localparam int CW = $clog2(WAKE_CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (sleep)       cnt <= CW'(WAKE_CYC);
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign blocked = sleep | (cnt != '0);

  // R8: the first edge after sleep falls is still blocked
  a_r8_recovery_block: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && $past(sleep)) |-> blocked);
endmodule

// File: rtl/lwsram_pipe.sv
module lwsram_pipe
  import lwsram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              start,
  input  logic              start_wr,
  input  logic [ADDR_W-1:0] addr,
  input  lanes_t            lane_en_n,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              commit,
  output logic [ADDR_W-1:0] c_addr,
  output lanes_t            c_lanes
);
  logic              s1_vld, s1_wr, s2_wr;
  logic [ADDR_W-1:0] s1_addr, s2_addr;
  lanes_t            s1_lanes, s2_lanes;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld   <= 1'b0;
      s1_wr    <= 1'b0;
      s1_addr  <= '0;
      s1_lanes <= '0;
      s2_wr    <= 1'b0;
      s2_addr  <= '0;
      s2_lanes <= '0;
    end else if (adv) begin
      s1_vld   <= start;
      s1_wr    <= start & start_wr;
      s1_addr  <= addr;
      s1_lanes <= ~lane_en_n;
      s2_wr    <= s1_vld & s1_wr;
      s2_addr  <= s1_addr;
      s2_lanes <= s1_lanes;
    end
  end

  assign rd_req  = s1_vld & ~s1_wr;
  assign rd_addr = s1_addr;
  assign commit  = s2_wr;
  assign c_addr  = s2_addr;
  assign c_lanes = s2_lanes;

  // R1: a taken command occupies stage one after the edge
  a_r1_cmd_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && start) |=> s1_vld);
  // R3: a write in stage one becomes the pending commit one edge later
  a_r3_write_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && s1_vld && s1_wr) |=> commit);
  // R5: a stalled edge leaves the pipeline untouched
  a_r5_pipe_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> ($stable(s1_vld) && $stable(s2_wr) && $stable(s2_addr)));
endmodule

// File: rtl/lwsram_store.sv
module lwsram_store
  import lwsram_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              commit,
  input  logic [ADDR_W-1:0] c_addr,
  input  lanes_t            c_lanes,
  input  word_t             wdata,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  output word_t             rdata_q,
  output logic              drive_q
);
  word_t  mem [DEPTH];
  logic   hit;
  lanes_t fwd_lanes;
  word_t  rd_word;

  assign hit       = commit & (c_addr == rd_addr);
  assign fwd_lanes = hit ? c_lanes : '0;
  assign rd_word   = lane_merge(mem[rd_addr], wdata, fwd_lanes);

  always_ff @(posedge clk) begin
    if (adv && commit) mem[c_addr] <= lane_merge(mem[c_addr], wdata, c_lanes);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_q <= 1'b0;
      rdata_q <= '0;
    end else if (adv) begin
      drive_q <= rd_req;
      if (rd_req) rdata_q <= rd_word;
    end
  end

  // R3/R6: no read in stage one means no drive after the edge
  a_r3_no_drive_without_read: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !rd_req) |=> !drive_q);
  // R5: a stalled edge keeps the output registers
  a_r5_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> ($stable(drive_q) && $stable(rdata_q)));
endmodule

// File: rtl/lwsram_core.sv
module lwsram_core
  import lwsram_pkg::*;
#(
  parameter int DEPTH    = 256,
  parameter int WAKE_CYC = 2,
  localparam int ADDR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en_n,
  input  logic              sel1_n,
  input  logic              sel2,
  input  logic              sel3_n,
  input  logic              load_n,
  input  logic              wr_n,
  input  logic [3:0]        lane_en_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [35:0]       wdata,
  input  logic              out_en_n,
  input  logic              sleep,
  output logic [35:0]       rdata,
  output logic              rdata_en
);
  logic              adv, blocked, start, start_wr;
  logic              rd_req, commit, drive_q;
  logic [ADDR_W-1:0] rd_addr, c_addr;
  lanes_t            c_lanes;
  word_t             rdata_q;

  assign adv = ~clk_en_n;

  lwsram_wake #(.WAKE_CYC(WAKE_CYC)) u_wake (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .blocked(blocked));

  lwsram_decode u_dec (
    .clk(clk), .rst_n(rst_n), .adv(adv), .sel1_n(sel1_n), .sel2(sel2),
    .sel3_n(sel3_n), .load_n(load_n), .wr_n(wr_n), .blocked(blocked),
    .start(start), .start_wr(start_wr));

  lwsram_pipe #(.ADDR_W(ADDR_W)) u_pipe (
    .clk(clk), .rst_n(rst_n), .adv(adv), .start(start), .start_wr(start_wr),
    .addr(addr), .lane_en_n(lane_en_n), .rd_req(rd_req), .rd_addr(rd_addr),
    .commit(commit), .c_addr(c_addr), .c_lanes(c_lanes));

  lwsram_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst_n(rst_n), .adv(adv), .commit(commit), .c_addr(c_addr),
    .c_lanes(c_lanes), .wdata(wdata), .rd_req(rd_req), .rd_addr(rd_addr),
    .rdata_q(rdata_q), .drive_q(drive_q));

  assign rdata_en = drive_q & ~out_en_n & ~sleep;
  assign rdata    = rdata_en ? rdata_q : '0;

  // R8: sleep keeps the bus undriven
  always_comb begin
    a_r8_sleep_hiz: assert (!(sleep && rdata_en));
  end
  // R9: reset leaves the core with nothing to drive
  a_r9_reset_idle: assert property (@(posedge clk)
    !rst_n |-> !rdata_en);
endmodule

// File: tb/lwsram_core_tb.sv
module lwsram_core_tb;
  localparam int DEP = 16;
  localparam int AW  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clk_en_n = 1'b0, sel1_n = 1'b1, sel2 = 1'b0, sel3_n = 1'b1;
  logic load_n = 1'b0, wr_n = 1'b1, out_en_n = 1'b0, sleep = 1'b0;
  logic [3:0]    lane_en_n = 4'hF;
  logic [AW-1:0] addr = '0;
  logic [35:0]   wdata = '0;
  logic [35:0]   rdata;
  logic          rdata_en;

  always #2.5 clk = ~clk;

  lwsram_core #(.DEPTH(DEP)) u_dut (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .sel1_n(sel1_n), .sel2(sel2),
    .sel3_n(sel3_n), .load_n(load_n), .wr_n(wr_n), .lane_en_n(lane_en_n),
    .addr(addr), .wdata(wdata), .out_en_n(out_en_n), .sleep(sleep),
    .rdata(rdata), .rdata_en(rdata_en));

  int errors = 0, checks = 0;
  bit finished = 1'b0;

  // reference model
  typedef struct { bit vld; bit wr; int a; bit [3:0] en_n; } cmd_t;
  cmd_t        pend[$];
  logic [35:0] ref_mem [DEP];
  bit          m_drive;
  logic [35:0] m_data;
  int          wake;

  task automatic model_reset();
    cmd_t idle;
    idle = '{vld: 0, wr: 0, a: 0, en_n: 4'hF};
    pend = {idle, idle};
    m_drive = 0; m_data = '0; wake = 0;
  endtask

  task automatic model_edge();
    cmd_t nc, old;
    bit can_start;
    can_start = !sleep && wake == 0;
    if (sleep) wake = 2; else if (wake > 0) wake--;
    if (clk_en_n) return;
    old = pend[0];
    if (old.vld && old.wr)
      for (int b = 0; b < 36; b++)
        if (!old.en_n[b/9]) ref_mem[old.a][b] = wdata[b];
    m_drive = pend[1].vld && !pend[1].wr;
    if (m_drive) m_data = ref_mem[pend[1].a];
    nc.vld = can_start && !sel1_n && sel2 && !sel3_n && !load_n;
    nc.wr  = !wr_n; nc.a = int'(addr); nc.en_n = lane_en_n;
    void'(pend.pop_front());
    pend.push_back(nc);
  endtask

  task automatic check(input string tag);
    bit exp_en;
    exp_en = m_drive && !out_en_n && !sleep;
    checks++;
    if (rdata_en !== exp_en) begin
      errors++;
      $display("FAIL %s: rdata_en=%0b expected %0b at %0t", tag, rdata_en, exp_en, $time);
    end else if (exp_en) begin
      checks++;
      if (rdata !== m_data) begin
        errors++;
        $display("FAIL %s: rdata=%h expected %h at %0t", tag, rdata, m_data, $time);
      end
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    if (!rst_n) model_reset(); else model_edge();
    @(negedge clk);
    check(tag);
  endtask

  task automatic cmd(input bit w, input int a, input bit [3:0] en_n);
    clk_en_n = 0; sel1_n = 0; sel2 = 1; sel3_n = 0; load_n = 0;
    wr_n = !w; addr = AW'(a); lane_en_n = en_n;
  endtask

  task automatic nop();
    clk_en_n = 0; sel1_n = 1; sel2 = 1; sel3_n = 0; load_n = 0;
  endtask

  initial begin
    model_reset();
    repeat (3) step("R9");
    rst_n = 1;
    // R9: nothing driven straight out of reset
    step("R9");

    // preload every word with full-lane writes (R3)
    for (int a = 0; a < DEP + 2; a++) begin
      if (a < DEP) cmd(1, a, 4'h0); else nop();
      wdata = {4'hA, 32'(a * 32'h01010101)};
      step("R3");
    end
    for (int a = 0; a < DEP; a++) begin cmd(0, a, 4'h0); step("R2"); end
    nop(); step("R2");

    // R7: write then immediate read of same word, partial lanes (R4)
    cmd(1, 5, 4'b1010); step("R7");
    cmd(0, 5, 4'hF); step("R7");
    wdata = 36'h123456789; nop(); step("R7");
    step("R4");
    cmd(0, 5, 4'hF); step("R4"); nop(); step("R4");

    // R4: write abort leaves the word untouched
    cmd(1, 6, 4'hF); step("R4");
    nop(); step("R4");
    wdata = 36'hFFFFFFFFF; cmd(0, 6, 4'h0); step("R4"); nop(); step("R4");

    // R5: stall between write and its data
    cmd(1, 7, 4'h0); step("R5");
    cmd(0, 7, 4'h0); step("R5");
    clk_en_n = 1; wdata = 36'h0DEADBEEF; step("R5"); step("R5");
    clk_en_n = 0; wdata = 36'h0CAFEF00D; nop(); step("R5");
    cmd(0, 7, 4'h0); step("R5"); nop(); step("R5");

    // R2: dummy read with output enable high, then enable mid-window
    cmd(0, 3, 4'h0); out_en_n = 1; step("R2");
    nop(); step("R2");
    out_en_n = 0; #1 check("R2");

    // R6 / R1: deselect and load_n high both idle the bus
    cmd(0, 2, 4'h0); step("R6");
    cmd(0, 2, 4'h0); load_n = 1; step("R1");
    sel2 = 0; load_n = 0; step("R6");
    step("R6");

    // R8: sleep and recovery window
    cmd(0, 1, 4'h0); step("R8");
    sleep = 1; step("R8"); step("R8");
    sleep = 0; step("R8"); step("R8"); step("R8");
    nop(); step("R8");

    // random mix (R1..R8)
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      clk_en_n  = (r < 15);
      sel1_n    = ($urandom_range(0, 9) == 0);
      sel2      = ($urandom_range(0, 9) != 0);
      sel3_n    = ($urandom_range(0, 19) == 0);
      load_n    = ($urandom_range(0, 9) == 0);
      wr_n      = $urandom_range(0, 1);
      lane_en_n = 4'($urandom_range(0, 15));
      addr      = AW'($urandom_range(0, 3));
      wdata     = {4'($urandom), 32'($urandom)};
      out_en_n  = ($urandom_range(0, 7) == 0);
      if (!sleep) sleep = ($urandom_range(0, 149) == 0);
      else        sleep = ($urandom_range(0, 2) != 0);
      step(r < 15 ? "R5" : (wr_n ? "R2" : "R7"));
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5 * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL R1: watchdog expired, actual hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule